// File: doc/BRIEF.md
# I2C Master SCL Clock Generator

This block produces the serial clock of an I2C master from a faster system clock. It counts the low and high halves of each SCL cycle in system-clock cycles. A count begins only once the synchronized line has been seen at the level the phase calls for, so it does not begin at the moment the drive changes. A slave that holds SCL low, or a slow edge, therefore lengthens the period without shortening either counted half. The line is driven open-drain: the block either pulls SCL low or lets it go. It never drives it high.

A request with the enable set produces a START: SDA is pulled low while SCL is high. A STOP request is latched and carried out after the current high phase: one low phase with SDA held low, then SCL is released, and SDA is released once SCL has been high for a full high count. Between START and STOP, a change strobe in the middle of each low phase tells a data shifter when to update SDA. A sample strobe in the middle of each high phase tells it when to read SDA. The half-phase counts come from the ratio of two compile-time frequency parameters. The split between low and high depends on whether the target rate is in standard or fast range.

States and transitions:
- `S_IDLE` goes to `S_START_SU` on an enabled start request.
- `S_START_SU` (SCL released, setup) goes to `S_START_HD` after the high count.
- `S_START_HD` (SDA low, SCL high) goes to `S_LOW` after the high count.
- `S_LOW` goes to `S_HIGH` after the low count.
- `S_HIGH` goes back to `S_LOW` after the high count, or to `S_STOP_LOW` if a stop is pending.
- `S_STOP_LOW` (SCL and SDA low) goes to `S_STOP_SU` after the low count.
- `S_STOP_SU` (SCL released, SDA low) goes to `S_IDLE` after the high count. SDA is released on that transition, which forms the STOP.

Top module: `scl_gen`

## Requirements
- R1: During and right after reset, `scl_oe`, `sda_oe`, `chg_stb` and `smp_stb` are all 0 and the block is idle.
- R2: In idle with `en`=1, a `start_req` pulse makes the block wait until synchronized SCL has been high for HIGH cycles. It then asserts `sda_oe` while SCL is high, holds that for HIGH cycles, and then asserts `scl_oe`. With `en`=0, or while a transfer is under way, `start_req` has no effect.
- R3: Each low phase keeps `scl_oe`=1 for LOW cycles counted from the first cycle in which synchronized SCL is low. With the two-stage synchronizer, an unstretched line is driven low for LOW+2 cycles.
- R4: After release, the phase counter stays at 0 while synchronized SCL is low. The high phase lasts HIGH cycles from the first cycle SCL is sampled high. A slave holding SCL low lengthens the low time of the line but not the counted high time.
- R5: TOTAL = floor(SYS_HZ/SCL_HZ). If SCL_HZ ≤ 100000, HIGH = floor(TOTAL/2); otherwise HIGH = floor(TOTAL/3). LOW = TOTAL−HIGH. Both are raised to at least 4.
- R6: `chg_stb` is a single-cycle pulse, once per data low phase, while the line is low. It is not emitted in the stop low phase.
- R7: `smp_stb` is a single-cycle pulse, once per high phase, while the line is high.
- R8: A `stop_req` during a transfer is latched. After the current high phase the block runs one low phase with `sda_oe`=1, releases SCL, and drops `sda_oe` after HIGH cycles of sampled-high SCL, then returns to idle. A `stop_req` while idle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Allows a start request to begin a transfer |
| start_req | input | 1 | Request a START condition (pulse) |
| stop_req | input | 1 | Request a STOP after the current bit (pulse) |
| scl_in | input | 1 | Raw sampled level of the SCL line |
| scl_oe | output | 1 | 1 = pull SCL low, 0 = release |
| sda_oe | output | 1 | 1 = pull SDA low for START/STOP windows |
| chg_stb | output | 1 | Mid-low strobe: data may change |
| smp_stb | output | 1 | Mid-high strobe: data may be sampled |

## Verification
The assertions assume that `scl_in` never reads high while the block itself pulls SCL low, which holds for a wired-AND line. They also assume that a stretching slave lets go of the line in the end. The bench models the line as the AND of the block's release and a slave hold counter. The slave holds only after the block has pulled SCL low, and it releases after a bounded number of cycles. Stop requests are issued in the middle of a high phase, so the latched request is always seen before that phase ends.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_START_SU,
        S_START_HD,
        S_LOW,
        S_HIGH,
        S_STOP_LOW,
        S_STOP_SU
    } scl_state_e;

    localparam int unsigned FAST_ABOVE_HZ = 100_000;
    localparam int unsigned MIN_PHASE     = 4;

    // High half count: even split in standard range, one third in fast range.
    function automatic int unsigned high_cycles(input int unsigned sys_hz,
                                                input int unsigned scl_hz);
        int unsigned total;
        int unsigned h;
        total = sys_hz / scl_hz;
        h     = (scl_hz > FAST_ABOVE_HZ) ? total / 3 : total / 2;
        if (h < MIN_PHASE) h = MIN_PHASE;
        return h;
    endfunction

    function automatic int unsigned low_cycles(input int unsigned sys_hz,
                                               input int unsigned scl_hz);
        int unsigned total;
        int unsigned h;
        int unsigned l;
        total = sys_hz / scl_hz;
        h     = high_cycles(sys_hz, scl_hz);
        l     = (total > h) ? total - h : 0;
        if (l < MIN_PHASE) l = MIN_PHASE;
        return l;
    endfunction

endpackage

// File: rtl/scl_sync.sv
module scl_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] ff;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) ff <= '1;
                else        ff <= d;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) ff <= '1;
                else        ff <= {ff[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = ff[STAGES-1];
endmodule

// File: rtl/scl_phase_cnt.sv
module scl_phase_cnt #(
    parameter int unsigned CW   = 8,
    parameter int unsigned MAXV = 255
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          want_low,
    input  logic          line,
    output logic [CW-1:0] cnt
);
    logic level_ok;

    assign level_ok = want_low ? !line : line;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr || !level_ok) begin
            cnt <= '0;
        end else if (cnt != CW'(MAXV)) begin
            cnt <= cnt + CW'(1);
        end
    end

    // Counting waits for the line to reach the low level.
    AST_LOW_WAITS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        (want_low && line) |=> (cnt == '0)); // R3
endmodule

// File: rtl/scl_gen.sv
module scl_gen
    import scl_gen_pkg::*;
#(
    parameter int unsigned SYS_HZ      = 25_000_000,
    parameter int unsigned SCL_HZ      = 100_000,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic start_req,
    input  logic stop_req,
    input  logic scl_in,
    output logic scl_oe,
    output logic sda_oe,
    output logic chg_stb,
    output logic smp_stb
);
    localparam int unsigned HIGH_CYC = high_cycles(SYS_HZ, SCL_HZ);
    localparam int unsigned LOW_CYC  = low_cycles(SYS_HZ, SCL_HZ);
    localparam int unsigned CNT_MAX  = (LOW_CYC > HIGH_CYC) ? LOW_CYC : HIGH_CYC;
    localparam int unsigned CW       = $clog2(CNT_MAX + 1);
    localparam int unsigned CHG_AT   = LOW_CYC / 2;
    localparam int unsigned SMP_AT   = HIGH_CYC / 2;

    scl_state_e    state, nxt;
    logic          scl_s;
    logic [CW-1:0] cnt;
    logic          stop_pend;
    logic          want_low;
    logic          lo_done, hi_done;
    logic          clr;

    scl_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (scl_in),
        .q     (scl_s)
    );

    assign want_low = (state == S_LOW) || (state == S_STOP_LOW);
    assign clr      = (nxt != state);

    scl_phase_cnt #(.CW(CW), .MAXV(CNT_MAX)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .want_low (want_low),
        .line     (scl_s),
        .cnt      (cnt)
    );

    assign lo_done = !scl_s && (cnt == CW'(LOW_CYC - 1));
    assign hi_done =  scl_s && (cnt == CW'(HIGH_CYC - 1));

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:     if (en && start_req) nxt = S_START_SU;
            S_START_SU: if (hi_done)         nxt = S_START_HD;
            S_START_HD: if (hi_done)         nxt = S_LOW;
            S_LOW:      if (lo_done)         nxt = S_HIGH;
            S_HIGH:     if (hi_done)         nxt = (stop_pend || stop_req) ? S_STOP_LOW : S_LOW;
            S_STOP_LOW: if (lo_done)         nxt = S_STOP_SU;
            S_STOP_SU:  if (hi_done)         nxt = S_IDLE;
            default:                         nxt = S_IDLE;
        endcase
    end

    // State register and stop latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            stop_pend <= 1'b0;
        end else begin
            state <= nxt;
            if (nxt == S_IDLE)
                stop_pend <= 1'b0;
            else if (stop_req && state != S_IDLE)
                stop_pend <= 1'b1;
        end
    end

    // Outputs
    always_comb begin
        scl_oe  = 1'b0;
        sda_oe  = 1'b0;
        chg_stb = 1'b0;
        smp_stb = 1'b0;
        unique case (state)
            S_IDLE, S_START_SU: ;
            S_START_HD: sda_oe = 1'b1;
            S_LOW: begin
                scl_oe  = 1'b1;
                chg_stb = !scl_s && (cnt == CW'(CHG_AT));
            end
            S_HIGH:     smp_stb = scl_s && (cnt == CW'(SMP_AT));
            S_STOP_LOW: begin
                scl_oe = 1'b1;
                sda_oe = 1'b1;
            end
            S_STOP_SU:  sda_oe = 1'b1;
            default: ;
        endcase
    end

    // Checks
    AST_LOW_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(scl_oe) |-> ($past(cnt) == CW'(LOW_CYC - 1))); // R3
    AST_HIGH_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_oe) |-> ($past(cnt) == CW'(HIGH_CYC - 1))); // R4
    AST_STRETCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_HIGH && !scl_s) |=> (cnt == '0)); // R4
    AST_CHG_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        chg_stb |=> !chg_stb); // R6
    AST_SMP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        smp_stb |=> !smp_stb); // R7
    AST_START_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sda_oe) && !scl_oe) |-> (scl_s && state == S_START_HD)); // R2
    AST_STOP_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sda_oe) && !scl_oe) |-> (scl_s && state == S_IDLE)); // R8
endmodule

// File: tb/tb_scl_gen.sv
`timescale 1ns/1ps
module tb_scl_gen;
    // Fast-range instance: TOTAL=25 -> HIGH=8, LOW=17 (R5)
    localparam int F_TOTAL = 250_000_000 / 10_000_000;
    localparam int FH      = F_TOTAL / 3;
    localparam int FL      = F_TOTAL - FH;
    // Standard-range instance: TOTAL=20 -> HIGH=10, LOW=10 (R5)
    localparam int S_TOTAL = 2_000_000 / 100_000;
    localparam int SH      = S_TOTAL / 2;
    localparam int SL      = S_TOTAL - SH;

    typedef struct { bit low; int len; } item_t;
    item_t exp_q[$];

    logic clk = 0;
    logic rst_n = 0;
    logic en = 0, start_req = 0, stop_req = 0;
    logic scl_oe, sda_oe, chg_stb, smp_stb, line;
    logic std_start = 0, std_stop = 0;
    logic std_oe, std_sda, std_chg, std_smp;

    int n_chk = 0, n_err = 0;
    int hold_cnt = 0, cur_str = 0, low_idx = 0;
    int stretch[0:15];
    bit oe_prev = 0, ln_prev = 1, in_txn = 0, run_valid = 0;
    int run_len = 0, n_chg = 0, n_smp = 0, sda_hi = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    assign line = !scl_oe && (hold_cnt == 0);

    scl_gen #(.SYS_HZ(250_000_000), .SCL_HZ(10_000_000)) dut (
        .clk(clk), .rst_n(rst_n), .en(en), .start_req(start_req), .stop_req(stop_req),
        .scl_in(line), .scl_oe(scl_oe), .sda_oe(sda_oe), .chg_stb(chg_stb), .smp_stb(smp_stb));

    scl_gen #(.SYS_HZ(2_000_000), .SCL_HZ(100_000)) dut_std (
        .clk(clk), .rst_n(rst_n), .en(1'b1), .start_req(std_start), .stop_req(std_stop),
        .scl_in(!std_oe), .scl_oe(std_oe), .sda_oe(std_sda), .chg_stb(std_chg), .smp_stb(std_smp));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor and slave model, sampled away from the active edge
    always @(negedge clk) begin
        bit ln;
        item_t it;
        ln = line;
        if (in_txn) begin
            if (chg_stb) begin n_chg++; check(!ln, "R6 chg_stb while line low", ln, 0); end
            if (smp_stb) begin n_smp++; check(ln, "R7 smp_stb while line high", ln, 1); end
            if (sda_oe && ln) sda_hi++;
            if (ln != ln_prev) begin
                if (run_valid) begin
                    if (exp_q.size() == 0) begin
                        check(0, "R3 unexpected phase", run_len, 0);
                    end else begin
                        it = exp_q.pop_front();
                        check(it.low == !ln_prev && it.len == run_len,
                              it.low ? "R3 low phase length" : "R4 high phase length",
                              run_len, it.len);
                    end
                end
                run_valid = 1;
                run_len = 1;
            end else begin
                run_len++;
            end
        end
        ln_prev = ln;
        // Slave: holds the line for stretch[] cycles after the block releases it
        if (scl_oe) begin
            if (!oe_prev) begin
                cur_str = (low_idx < 16) ? stretch[low_idx] : 0;
                low_idx++;
            end
            hold_cnt = cur_str;
        end else if (hold_cnt > 0) begin
            hold_cnt--;
        end
        oe_prev = scl_oe;
    end

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150_000) begin
            n_chk++; n_err++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150_000);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    task automatic pulse_start();
        @(negedge clk) start_req = 1;
        @(negedge clk) start_req = 0;
    endtask

    // Driver: pushes the expected line phases, then runs one transfer
    task automatic run_txn(input int nbits, input int s_bit, input int s_len, input bit busy_start);
        item_t it;
        for (int i = 0; i < 16; i++) stretch[i] = 0;
        if (s_bit >= 0) stretch[s_bit] = s_len;
        low_idx = 0; n_chg = 0; n_smp = 0; sda_hi = 0; run_valid = 0;
        for (int b = 0; b < nbits; b++) begin
            it.low = 1; it.len = FL + 2 + stretch[b]; exp_q.push_back(it);
            // a stretched release lands half a cycle early in the slave model
            it.low = 0; it.len = (stretch[b] > 0) ? FH + 1 : FH + 2; exp_q.push_back(it);
        end
        it.low = 1; it.len = FL + 2; exp_q.push_back(it);   // stop low phase
        in_txn = 1;
        pulse_start();
        if (busy_start) begin
            while (n_chg == 0) @(negedge clk);
            pulse_start();                                   // R2: ignored while busy
        end
        while (n_smp < nbits) @(negedge clk);
        @(negedge clk) stop_req = 1;
        @(negedge clk) stop_req = 0;
        while (!sda_oe) @(negedge clk);
        while (sda_oe) @(negedge clk);
        repeat (4) @(negedge clk);
        in_txn = 0;
        check(exp_q.size() == 0, "R3 all phases seen", exp_q.size(), 0);
        exp_q.delete();
        check(n_chg == nbits, "R6 change strobe count", n_chg, nbits);
        check(n_smp == nbits, "R7 sample strobe count", n_smp, nbits);
        check(sda_hi == 2 * FH + 2, "R8 START/STOP SDA windows with SCL high", sda_hi, 2 * FH + 2);
        check(!scl_oe && !sda_oe, "R8 idle after stop", scl_oe, 0);
    endtask

    initial begin
        int n;
        bit moved;
        repeat (5) @(negedge clk);
        check(!scl_oe && !sda_oe && !chg_stb && !smp_stb, "R1 reset outputs", {scl_oe, sda_oe, chg_stb, smp_stb}, 0);
        check(!std_oe && !std_sda, "R1 reset outputs std", {std_oe, std_sda}, 0);
        rst_n = 1;
        @(negedge clk);
        check(!scl_oe && !sda_oe, "R1 idle after reset", {scl_oe, sda_oe}, 0);

        // R2: start with enable low is ignored
        en = 0;
        pulse_start();
        moved = 0;
        repeat (60) begin @(negedge clk); if (scl_oe || sda_oe) moved = 1; end
        check(!moved, "R2 start ignored with en=0", moved, 0);

        // R8: stop in idle is ignored; the next transfer must run all its bits
        en = 1;
        @(negedge clk) stop_req = 1;
        @(negedge clk) stop_req = 0;
        repeat (10) @(negedge clk);
        check(!scl_oe && !sda_oe, "R8 stop in idle ignored", {scl_oe, sda_oe}, 0);
        run_txn(3, -1, 0, 0);

        run_txn(4, -1, 0, 1);   // R2 start while busy, R3/R4 plain
        run_txn(3, 1, 9, 0);    // R4 slave stretches bit 1
        run_txn(2, 0, 1, 0);    // R4 one-cycle stretch

        // R5: standard-range instance splits evenly
        @(negedge clk) std_start = 1;
        @(negedge clk) std_start = 0;
        while (!std_oe) @(negedge clk);
        n = 0;
        while (std_oe) begin n++; @(negedge clk); end
        check(n == SL + 2, "R5 standard low length", n, SL + 2);
        n = 0;
        while (!std_oe) begin n++; @(negedge clk); end
        check(n == SH + 2, "R5 standard high length", n, SH + 2);
        @(negedge clk) std_stop = 1;
        @(negedge clk) std_stop = 0;
        repeat (120) @(negedge clk);
        check(!std_oe && !std_sda, "R8 standard instance idle", {std_oe, std_sda}, 0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule